// File: doc/BRIEF.md
# USB Interrupt Enable and Threshold Gate

This block turns five USB controller status conditions into a single interrupt request line. Each condition has a sticky status bit, set by a one-cycle event pulse from the controller logic, and an enable bit. Software reads both registers through a small register port. It acknowledges a condition by writing a one to the matching status bit.

Three of the sources raise the interrupt as soon as their status bit is set and enabled: system error, frame-list rollover and port change. The transfer-complete source and the bus-error source are held back. They only reach the output when a programmable interval of microframe ticks has run out. The interval counter opens a one-tick release window at each boundary. Whatever deferred conditions are then set and enabled are latched and drive the output until software clears them. The frame-list rollover source only works while the controller runs as a host.

Top module: `usb_irq_gate`

## Requirements
- R1: The enable register (reg_sel=0) reads back the last written value. Bit 0 is transfer complete, bit 1 is bus error, bit 2 is port change, bit 3 is frame-list rollover and bit 4 is system error.
- R2: A pulse on evt[i] sets status bit i (reg_sel=1 readback), using the same bit order as R1. The bit is visible from the clock edge that samples the pulse.
- R3: Writing to the status register clears each bit written as 1. Bits written as 0 keep their value.
- R4: If an event and a clear hit the same status bit in the same cycle, the bit stays set.
- R5: When status bit 2, 3 or 4 is set and enabled, irq is high right after the edge that sets it, with no wait for a tick.
- R6: Status bits 0 and 1 raise irq only at a release boundary. A bit that is set and enabled before the edge where the release tick is sampled raises irq right after that edge. If it is set later, it waits for the next boundary.
- R7: The release boundary falls on every Nth sampled uframe_tick, where N is thresh in the range 1 to 64. A thresh of 0 acts as 1, and a value above 64 acts as 64.
- R8: When host_mode is 0, a rollover event (bit 3) is ignored and status bit 3 stays 0. When host_mode is 1, it works like the other immediate sources.
- R9: irq falls right after the edge where the last condition that is both set and enabled goes away. This can happen by a status clear or by an enable write.
- R10: After reset both registers are 0, the interval count is 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode | input | 1 | 1 = host role, 0 = device role |
| evt | input | 5 | Event pulses, one per status bit |
| uframe_tick | input | 1 | One-cycle pulse per microframe |
| thresh | input | 7 | Release interval in microframes |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = enable register, 1 = status register |
| reg_wdata | input | 5 | Write data |
| reg_rdata | output | 5 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
Status bits, enable bits and the deferred latch are all registered, and irq and reg_rdata are combinational from them. Every result is therefore due one edge after the event pulse, register write or tick that causes it. The bench drives each stimulus for exactly one clock and samples on the falling edge right after that clock. For deferred sources it counts ticks so that it can show irq low on the tick before a boundary and high on the tick that ends it.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
   localparam int SRC_N     = 5;
   localparam int IX_XFER   = 0;
   localparam int IX_BUSERR = 1;
   localparam int IX_PORT   = 2;
   localparam int IX_ROLL   = 3;
   localparam int IX_SYSERR = 4;
   localparam logic [SRC_N-1:0] DEFER_MASK = 5'b00011;
endpackage

// File: rtl/usb_irq_regs.sv
module usb_irq_regs #(
   parameter int N         = 5,
   parameter int ROLL_IX   = 3,
   parameter bit ROLL_HOST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         host_mode,
   input  logic [N-1:0] evt,
   input  logic         reg_wr,
   input  logic         reg_sel,
   input  logic [N-1:0] reg_wdata,
   output logic [N-1:0] en_q,
   output logic [N-1:0] st_q
);
   localparam logic [N-1:0] ROLL_BIT = N'(1) << ROLL_IX;

   if (ROLL_IX >= N) begin : g_bad_ix
      $error("rollover index outside source range");
   end

   logic [N-1:0] set_v;
   logic [N-1:0] clr_v;

   if (ROLL_HOST) begin : g_roll_gated
      assign set_v = host_mode ? evt : (evt & ~ROLL_BIT);
   end else begin : g_roll_free
      assign set_v = evt;
   end

   assign clr_v = (reg_wr && reg_sel) ? reg_wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
         st_q <= '0;
      end else begin
         if (reg_wr && !reg_sel) en_q <= reg_wdata;
         st_q <= (st_q & ~clr_v) | set_v;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_chk
      // R3: a written 1 without a same-cycle event clears the bit
      a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_wr && reg_sel && reg_wdata[i] && !evt[i]) |=> !st_q[i]);
      // R4: an event always leaves the bit set
      a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (set_v[i]) |=> st_q[i]);
   end

   if (ROLL_HOST) begin : g_roll_chk
      // R8: rollover status never rises in device role
      a_r8_device_roll: assert property (@(posedge clk) disable iff (!rst_n)
         (!host_mode) |=> !$rose(st_q[ROLL_IX]));
   end
endmodule

// File: rtl/usb_irq_thresh.sv
module usb_irq_thresh #(
   parameter int THR_W   = 7,
   parameter int MAX_THR = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [THR_W-1:0] thresh,
   output logic             open_win
);
   if (MAX_THR < 1 || MAX_THR >= (1 << THR_W)) begin : g_bad_thr
      $error("MAX_THR must fit in THR_W bits");
   end

   logic [THR_W-1:0] cnt_q;
   logic [THR_W-1:0] lim;
   logic [THR_W:0]   nxt;

   always_comb begin
      if (thresh == '0)                    lim = THR_W'(1);
      else if (thresh > THR_W'(MAX_THR))   lim = THR_W'(MAX_THR);
      else                                 lim = thresh;
   end

   assign nxt      = {1'b0, cnt_q} + 1'b1;
   assign open_win = tick && (nxt >= {1'b0, lim});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (open_win) cnt_q <= '0;
      else if (tick)     cnt_q <= nxt[THR_W-1:0];
   end

   // R7: the interval count stays below the largest interval
   a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < THR_W'(MAX_THR));
endmodule

// File: rtl/usb_irq_gate.sv
module usb_irq_gate
   import usb_irq_pkg::*;
#(
   parameter int THR_W     = 7,
   parameter int MAX_THR   = 64,
   parameter bit ROLL_HOST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_mode,
   input  logic [4:0]       evt,
   input  logic             uframe_tick,
   input  logic [THR_W-1:0] thresh,
   input  logic             reg_wr,
   input  logic             reg_sel,
   input  logic [4:0]       reg_wdata,
   output logic [4:0]       reg_rdata,
   output logic             irq
);
   localparam int ND = $countones(DEFER_MASK);

   logic [SRC_N-1:0] en_q, st_q, act;
   logic             open_win;
   logic [ND-1:0]    pend_q, def_act;
   logic             imm_irq, def_irq;

   usb_irq_regs #(.N(SRC_N), .ROLL_IX(IX_ROLL), .ROLL_HOST(ROLL_HOST)) u_regs (
      .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .evt(evt),
      .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .en_q(en_q), .st_q(st_q));

   usb_irq_thresh #(.THR_W(THR_W), .MAX_THR(MAX_THR)) u_thr (
      .clk(clk), .rst_n(rst_n), .tick(uframe_tick), .thresh(thresh),
      .open_win(open_win));

   assign reg_rdata = reg_sel ? st_q : en_q;
   assign act       = st_q & en_q;

   if (ROLL_HOST) begin : g_imm_host
      assign imm_irq = act[IX_SYSERR] | act[IX_PORT] | (act[IX_ROLL] & host_mode);
   end else begin : g_imm_any
      assign imm_irq = act[IX_SYSERR] | act[IX_PORT] | act[IX_ROLL];
   end

   assign def_act = {act[IX_BUSERR], act[IX_XFER]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_q <= '0;
      else if (open_win) pend_q <= def_act;
      else               pend_q <= pend_q & def_act;
   end

   assign def_irq = |(pend_q & def_act);
   assign irq     = imm_irq | def_irq;

   // R6: a deferred source is latched only in a release window
   a_r6_latch_at_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|pend_q) |-> $past(open_win));
   // R5: an active immediate source holds the line high
   a_r5_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      (act[IX_PORT] || act[IX_SYSERR]) |-> irq);
   // R9: nothing active means no request
   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (act == '0) |-> !irq);
endmodule

// File: tb/usb_irq_gate_test.sv
module usb_irq_gate_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_mode = 1'b1;
   logic [4:0] evt = '0;
   logic       uframe_tick = 1'b0;
   logic [6:0] thresh = 7'd64;
   logic       reg_wr = 1'b0;
   logic       reg_sel = 1'b0;
   logic [4:0] reg_wdata = '0;
   logic [4:0] reg_rdata;
   logic       irq;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   usb_irq_gate uut (.clk(clk), .rst_n(rst_n), .host_mode(host_mode), .evt(evt),
      .uframe_tick(uframe_tick), .thresh(thresh), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   // {host, enable, event, expected status, expected irq}
   localparam int NV = 8;
   localparam logic [16:0] VEC [NV] = '{
      {1'b1, 5'h04, 5'h04, 5'h04, 1'b1},
      {1'b1, 5'h10, 5'h10, 5'h10, 1'b1},
      {1'b1, 5'h08, 5'h08, 5'h08, 1'b1},
      {1'b0, 5'h08, 5'h08, 5'h00, 1'b0},
      {1'b1, 5'h01, 5'h01, 5'h01, 1'b0},
      {1'b1, 5'h00, 5'h1C, 5'h1C, 1'b0},
      {1'b1, 5'h1F, 5'h02, 5'h02, 1'b0},
      {1'b1, 5'h03, 5'h04, 5'h04, 1'b0}
   };

   task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [4:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic pulse(input logic [4:0] e);
      @(negedge clk); evt = e;
      @(negedge clk); evt = '0;
   endtask

   task automatic tick();
      @(negedge clk); uframe_tick = 1'b1;
      @(negedge clk); uframe_tick = 1'b0;
   endtask

   task automatic rd_status(input string req, input logic [4:0] exp);
      reg_sel = 1'b1; #1; chk(req, reg_rdata, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      reg_sel = 1'b0; #1; chk("R10 enable", reg_rdata, 5'h00);
      rd_status("R10 status", 5'h00);
      chk("R10 irq", {4'b0, irq}, 5'h00);
      rst_n = 1'b1;

      // R1 R2 R5 R6 R8: vector table, no ticks so deferred bits stay held back
      for (int v = 0; v < NV; v++) begin
         wr(1'b1, 5'h1F);
         host_mode = VEC[v][16];
         wr(1'b0, VEC[v][15:11]);
         reg_sel = 1'b0; #1; chk("R1 enable readback", reg_rdata, VEC[v][15:11]);
         pulse(VEC[v][10:6]);
         rd_status("R2/R8 status", VEC[v][5:1]);
         chk("R5/R6 irq", {4'b0, irq}, {4'b0, VEC[v][0]});
      end
      wr(1'b1, 5'h1F);
      host_mode = 1'b1;

      // fresh interval count
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;

      // R6 R7: interval of 3
      thresh = 7'd3;
      wr(1'b0, 5'h01);
      pulse(5'h01);
      tick(); chk("R6 tick1", {4'b0, irq}, 5'h00);
      tick(); chk("R6 tick2", {4'b0, irq}, 5'h00);
      tick(); chk("R7 tick3", {4'b0, irq}, 5'h01);
      // R9: clearing drops the line
      wr(1'b1, 5'h01); chk("R9 clear deferred", {4'b0, irq}, 5'h00);

      // R3: writing zeros leaves status alone
      wr(1'b0, 5'h10);
      pulse(5'h10); chk("R5 syserr", {4'b0, irq}, 5'h01);
      wr(1'b1, 5'h00); rd_status("R3 zero write", 5'h10);
      wr(1'b1, 5'h10); rd_status("R3 one write", 5'h00);

      // R4: set and clear in one cycle
      wr(1'b0, 5'h04);
      @(negedge clk); evt = 5'h04; reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 5'h04;
      @(negedge clk); evt = '0; reg_wr = 1'b0;
      rd_status("R4 set wins", 5'h04);
      chk("R4 irq", {4'b0, irq}, 5'h01);
      // R9: enable removal drops the line, status kept
      wr(1'b0, 5'h00); chk("R9 enable off", {4'b0, irq}, 5'h00);
      rd_status("R9 status kept", 5'h04);
      wr(1'b1, 5'h1F);

      // R6: event after a boundary waits for the next one (count at 0)
      thresh = 7'd2;
      wr(1'b0, 5'h02);
      tick(); tick();
      pulse(5'h02); chk("R6 after boundary", {4'b0, irq}, 5'h00);
      tick(); chk("R6 mid interval", {4'b0, irq}, 5'h00);
      tick(); chk("R6 next boundary", {4'b0, irq}, 5'h01);
      wr(1'b1, 5'h1F);

      // R7: zero acts as one
      thresh = 7'd0;
      wr(1'b0, 5'h01);
      pulse(5'h01); chk("R7 thr0 before", {4'b0, irq}, 5'h00);
      tick(); chk("R7 thr0 release", {4'b0, irq}, 5'h01);
      wr(1'b1, 5'h1F);

      // R7: longest interval
      thresh = 7'd64;
      pulse(5'h01);
      for (int t = 1; t < 64; t++) tick();
      chk("R7 tick63", {4'b0, irq}, 5'h00);
      tick(); chk("R7 tick64", {4'b0, irq}, 5'h01);
      wr(1'b1, 5'h1F);

      // R8: rollover by role
      host_mode = 1'b0; wr(1'b0, 5'h08);
      pulse(5'h08); rd_status("R8 device ignored", 5'h00);
      chk("R8 device irq", {4'b0, irq}, 5'h00);
      host_mode = 1'b1;
      pulse(5'h08); chk("R8 host irq", {4'b0, irq}, 5'h01);
      wr(1'b1, 5'h1F);

      // R9: line stays up until the last active source is cleared
      wr(1'b0, 5'h1C);
      pulse(5'h14); chk("R5 two sources", {4'b0, irq}, 5'h01);
      wr(1'b1, 5'h04); chk("R9 one left", {4'b0, irq}, 5'h01);
      wr(1'b1, 5'h10); chk("R9 none left", {4'b0, irq}, 5'h00);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule